// File: doc/BRIEF.md
# Ring Oscillator Frequency Meter

This block measures the frequency of a free-running on-chip oscillator by counting reference-clock cycles. The count runs while the oscillator completes a programmed number of its own cycles. Software loads a target cycle count, usually 1024, and sets the enable bit. Once the valid flag in the status register is set, software reads the reference count from the result register. The oscillator frequency is the reference frequency times the target count divided by the result, so a faster oscillator gives a smaller result.

The block has two clock domains. The reference domain holds the registers and a four-state controller (IDLE, ARM, MEASURE, DONE). The oscillator domain holds a three-state gate counter (O_IDLE, O_RUN, O_HOLD). A level request crosses from the reference domain to the oscillator domain, and a level done flag crosses back, each through a two-flop synchroniser. A separate free-run enable, also synchronised, gates the oscillator cycles into the gate counter.

Reference controller transitions:
- IDLE→ARM when enable is set. The target count is captured on this transition.
- ARM→MEASURE when the synchronised done flag is low. The reference counter was cleared in ARM.
- MEASURE→DONE when the synchronised done flag rises. The count is latched as the result and valid is set.
- Any state→IDLE when enable is cleared.

Gate counter transitions:
- O_IDLE→O_RUN on request.
- O_RUN→O_HOLD when the gated cycle count reaches the target. Done goes high.
- O_RUN or O_HOLD→O_IDLE when the request drops.

Top module: `osc_freq_meter`

## Requirements
- R1: After reset, all three registers read zero.
- R2: The registers are word-addressed. Writes to address 0 set the target count (bits 23:0) and the enable bit (bit 24); bits 31:25 read as zero. At address 1, bit 8 is the writable free-run enable and bit 0 is the read-only valid flag. Address 2 holds the read-only result. Writes to read-only bits have no effect.
- R3: The result is the number of reference cycles in MEASURE. It lies between N·Tosc/Tref − 1 and (N+5)·Tosc/Tref + 6, where N is the target count.
- R4: Valid rises when a measurement completes. The result stays stable while valid and enable are both set.
- R5: The reference counter saturates at all ones and does not wrap. The result then reads all ones.
- R6: While the free-run enable is clear, no oscillator cycles are counted and valid stays low. Setting the free-run enable lets the measurement complete.
- R7: Clearing enable returns the controller to IDLE and clears valid and the result on the next reference edge, even in the middle of a measurement. A measurement started afterwards is not affected by the aborted one.
- R8: Only a rising edge of enable starts a new measurement. Writing the control register again with enable still set does not restart the measurement or change the result.
- R9: A target count of zero behaves like a target count of one.
- R10: Valid is low in ARM and MEASURE and high only in DONE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; registers and controller |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| osc_clk | input | 1 | Oscillator clock being measured |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 status, 2 result |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |

## Verification
A register write is visible on a read one reference cycle later. Clearing enable clears valid and the result one reference cycle after the write. A valid flag is due only after N gated oscillator cycles plus two to three synchroniser cycles in each direction, so the bench polls the status register at falling edges with a bounded timeout and does not expect valid at a fixed cycle. Result values are checked against a window computed from the two clock periods, and the window's width covers the synchroniser uncertainty.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {R_IDLE, R_ARM, R_MEAS, R_DONE} ref_st_t;
    typedef enum logic [1:0] {O_IDLE, O_RUN, O_HOLD} osc_st_t;

    localparam int EN_BIT    = 24;
    localparam int FRUN_BIT  = 8;
    localparam int VALID_BIT = 0;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_RES  = 2'd2;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/fm_regs.sv
module fm_regs
    import fm_pkg::*;
#(
    parameter int TGT_W = 24,
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic [TGT_W-1:0] tgt,
    output logic             meas_en,
    output logic             free_run,
    input  logic             valid,
    input  logic [RES_W-1:0] result
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt      <= '0;
            meas_en  <= 1'b0;
            free_run <= 1'b0;
        end else if (wr) begin
            if (addr == A_CTRL) begin
                tgt     <= wdata[TGT_W-1:0];
                meas_en <= wdata[EN_BIT];
            end else if (addr == A_STAT) begin
                free_run <= wdata[FRUN_BIT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[TGT_W-1:0] = tgt;
                rdata[EN_BIT]    = meas_en;
            end
            A_STAT: begin
                rdata[FRUN_BIT]  = free_run;
                rdata[VALID_BIT] = valid;
            end
            A_RES:   rdata[RES_W-1:0] = result;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/fm_ref_fsm.sv
module fm_ref_fsm
    import fm_pkg::*;
#(
    parameter int TGT_W = 24,
    parameter int RES_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             meas_en,
    input  logic [TGT_W-1:0] tgt_in,
    input  logic             done_s,
    output logic             req,
    output logic [TGT_W-1:0] tgt_hold,
    output logic             valid,
    output logic [RES_W-1:0] result
);
    localparam logic [RES_W-1:0] CNT_MAX = '1;

    ref_st_t          state, nxt;
    logic [RES_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= R_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            R_IDLE: if (meas_en) nxt = R_ARM;
            R_ARM:  if (!meas_en) nxt = R_IDLE; else if (!done_s) nxt = R_MEAS;
            R_MEAS: if (!meas_en) nxt = R_IDLE; else if (done_s) nxt = R_DONE;
            R_DONE: if (!meas_en) nxt = R_IDLE;
            default: nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req      <= 1'b0;
            tgt_hold <= '0;
            cnt      <= '0;
            valid    <= 1'b0;
            result   <= '0;
        end else begin
            req   <= (nxt == R_MEAS) || (nxt == R_DONE);
            valid <= (nxt == R_DONE);
            if (state == R_IDLE && meas_en) tgt_hold <= tgt_in;
            if (state == R_ARM) cnt <= '0;
            else if (state == R_MEAS && nxt == R_MEAS && cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (state == R_MEAS && nxt == R_DONE) result <= cnt;
            else if (nxt != R_DONE)               result <= '0;
        end
    end

    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == R_MEAS && cnt == CNT_MAX) |=> (state != R_MEAS || cnt == CNT_MAX));
    a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_en |=> (!valid && result == '0));
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == R_DONE && meas_en) |=> (state == R_DONE && valid));
    a_r4_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && meas_en) |=> $stable(result));
    a_r10_arm_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == R_IDLE && meas_en) |=> (state == R_ARM && !valid));
endmodule

// File: rtl/fm_osc_count.sv
module fm_osc_count
    import fm_pkg::*;
#(
    parameter int TGT_W = 24
) (
    input  logic             osc_clk,
    input  logic             osc_rst_n,
    input  logic             req_s,
    input  logic             gate_s,
    input  logic [TGT_W-1:0] tgt,
    output logic             done
);
    osc_st_t          state, nxt;
    logic [TGT_W-1:0] cnt;
    logic [TGT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) state <= O_IDLE;
        else            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            O_IDLE: if (req_s) nxt = O_RUN;
            O_RUN:  if (!req_s) nxt = O_IDLE;
                    else if (gate_s && cnt_inc >= {1'b0, tgt}) nxt = O_HOLD;
            O_HOLD: if (!req_s) nxt = O_IDLE;
            default: nxt = O_IDLE;
        endcase
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= (nxt == O_HOLD);
            if (state != O_RUN)  cnt <= '0;
            else if (gate_s)     cnt <= cnt_inc[TGT_W-1:0];
        end
    end

    a_r6_gate_freezes: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        (state == O_RUN && req_s && !gate_s) |=> (state == O_RUN && $stable(cnt)));
    a_r7_done_drops: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        !req_s |=> !done);
endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
    import fm_pkg::*;
#(
    parameter int TGT_W = 24,
    parameter int RES_W = 24
) (
    input  logic        ref_clk,
    input  logic        rst_n,
    input  logic        osc_clk,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    logic [TGT_W-1:0] tgt, tgt_hold;
    logic             meas_en, free_run, valid, req, done, done_s, osc_rst_n;
    logic [RES_W-1:0] result;
    logic [1:0]       osc_in_s;

    fm_regs #(.TGT_W(TGT_W), .RES_W(RES_W)) u_regs (
        .clk(ref_clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .tgt(tgt), .meas_en(meas_en),
        .free_run(free_run), .valid(valid), .result(result));

    fm_ref_fsm #(.TGT_W(TGT_W), .RES_W(RES_W)) u_ref (
        .clk(ref_clk), .rst_n(rst_n), .meas_en(meas_en), .tgt_in(tgt),
        .done_s(done_s), .req(req), .tgt_hold(tgt_hold), .valid(valid),
        .result(result));

    fm_sync #(.W(1)) u_osc_rst (
        .clk(osc_clk), .rst_n(rst_n), .d(1'b1), .q(osc_rst_n));

    fm_sync #(.W(2)) u_to_osc (
        .clk(osc_clk), .rst_n(osc_rst_n), .d({free_run, req}), .q(osc_in_s));

    fm_sync #(.W(1)) u_to_ref (
        .clk(ref_clk), .rst_n(rst_n), .d(done), .q(done_s));

    fm_osc_count #(.TGT_W(TGT_W)) u_osc (
        .osc_clk(osc_clk), .osc_rst_n(osc_rst_n), .req_s(osc_in_s[0]),
        .gate_s(osc_in_s[1]), .tgt(tgt_hold), .done(done));
endmodule

// File: tb/sim_osc_freq_meter.sv
`timescale 1ns/1ps
module sim_osc_freq_meter;
    localparam int RW = 12;
    localparam int RMAX = (1 << RW) - 1;

    logic        clk = 1'b0, osc = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    int          osc_half = 5;
    int          checks = 0, fails = 0;
    bit          finished = 1'b0;

    osc_freq_meter #(.TGT_W(24), .RES_W(RW)) u0 (
        .ref_clk(clk), .rst_n(rst_n), .osc_clk(osc), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #2 clk = ~clk;
    always #(osc_half * 1.0) osc = ~osc;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_valid(input int limit, output bit got);
        logic [31:0] s;
        got = 1'b0;
        for (int i = 0; i < limit && !got; i++) begin
            rd(2'd1, s);
            got = s[0];
        end
    endtask

    // Window for a result, from the two periods (ref period 4 ns)
    task automatic measure_chk(input string tag, input int n, input int half);
        bit got;
        logic [31:0] r;
        int nef;
        nef = (n == 0) ? 1 : n;
        wait_valid(20000, got);
        chk({tag, " valid"}, {31'd0, got}, 32'd1);
        rd(2'd2, r);
        chk_rng(tag, int'(r), (nef * 2 * half) / 4 - 1, ((nef + 5) * 2 * half) / 4 + 6);
    endtask

    initial begin
        logic [31:0] v, r0;
        bit got;
        idle(3);
        rst_n = 1'b1;
        idle(4);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(2'd1, v); chk("R1 status", v, 32'h0);
        rd(2'd2, v); chk("R1 result", v, 32'h0);

        // R2 field layout and read-only bits
        wr(2'd0, 32'h00AB_CDEF); rd(2'd0, v); chk("R2 ctrl count", v, 32'h00AB_CDEF);
        wr(2'd0, 32'hFE00_0000); rd(2'd0, v); chk("R2 ctrl upper ignored", v, 32'h0);
        wr(2'd1, 32'h0000_0101); rd(2'd1, v); chk("R2 status valid ro", v, 32'h0000_0100);
        wr(2'd2, 32'h0000_0123); rd(2'd2, v); chk("R2 result ro", v, 32'h0);

        // R3/R4/R10 measurement, ratio 2.5
        osc_half = 5;
        wr(2'd0, 32'h0100_0040);
        rd(2'd1, v); chk("R10 valid low while measuring", v & 32'h1, 32'h0);
        measure_chk("R3 n64 half5", 64, 5);
        rd(2'd2, r0); idle(40); rd(2'd2, v); chk("R4 result stable", v, r0);

        // R8 rewrite with enable still set
        wr(2'd0, 32'h0100_0008); idle(30);
        rd(2'd1, v); chk("R8 valid kept", v & 32'h1, 32'h1);
        rd(2'd2, v); chk("R8 result unchanged", v, r0);

        // R7 clear
        wr(2'd0, 32'h0); idle(2);
        rd(2'd1, v); chk("R7 valid cleared", v & 32'h1, 32'h0);
        rd(2'd2, v); chk("R7 result cleared", v, 32'h0);

        // R3 second pattern, ratio 1.5
        osc_half = 3; idle(10);
        wr(2'd0, 32'h0100_0400);
        measure_chk("R3 n1024 half3", 1024, 3);
        wr(2'd0, 32'h0); idle(20);

        // R9 zero target
        osc_half = 5; idle(10);
        wr(2'd0, 32'h0100_0000);
        measure_chk("R9 zero target", 0, 5);
        wr(2'd0, 32'h0); idle(20);

        // R6 free-run gate
        wr(2'd1, 32'h0); wr(2'd0, 32'h0100_0010); idle(3000);
        rd(2'd1, v); chk("R6 no valid without free-run", v & 32'h1, 32'h0);
        wr(2'd1, 32'h100);
        wait_valid(2000, got); chk("R6 completes after free-run", {31'd0, got}, 32'd1);
        wr(2'd0, 32'h0); idle(20);

        // R7 abort mid-measurement, then fresh run (ratio 10)
        osc_half = 20; idle(10);
        wr(2'd0, 32'h0100_0400); idle(100);
        wr(2'd0, 32'h0); idle(1);
        rd(2'd1, v); chk("R7 abort valid low", v & 32'h1, 32'h0);
        rd(2'd2, v); chk("R7 abort result zero", v, 32'h0);
        idle(50);
        wr(2'd0, 32'h0100_0008);
        measure_chk("R7 fresh after abort", 8, 20);
        wr(2'd0, 32'h0); idle(40);

        // R5 saturation: 1024 * 10 exceeds 12-bit counter
        wr(2'd0, 32'h0100_0400);
        wait_valid(20000, got); chk("R5 valid", {31'd0, got}, 32'd1);
        rd(2'd2, v); chk("R5 saturated", v, RMAX);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4.0 * 150000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule